// File: doc/BRIEF.md
# Host Address Remap Window

This block translates addresses that a host presents on its firmware-space bus into addresses on a local memory bus, through one programmable window. Software configures the window with four 32-bit registers written through a plain write port. Two of them hold the window geometry. The third enables translation. The fourth holds interrupt status bits together with a forwarding-mode bit.

Each host address strobe produces, one clock later, a result flag that reports whether the address fell inside the window. On a hit the block also outputs the rebuilt local address. Only address bits 31:16 take part in the window arithmetic, so window sizes and offsets are whole multiples of 64 KiB. The low 16 bits always pass through unchanged.

To open a window of power-of-two size S, software loads the mask register with the inverse of S-1 in its upper half and with (S>>16)-1 in its lower half. The window offset must be a multiple of S.

Top module: `hrw_remap_window`

## Requirements
- R1: After reset every configuration register and the status register read as zero, `xlat_valid`, `xlat_hit`, `xlat_addr` and `fwd_mode` are 0, and no lookup hits.
- R2: A write with `cfg_we`=1 takes effect at the next rising clock edge, and `cfg_sel` chooses the target. Select 0 is the base register: bits 31:16 hold the local base and bits 15:0 hold the host base. Select 1 is the mask register: bits 31:16 hold the replace mask and bits 15:0 hold the keep mask. Select 2 is the enable register. Select 3 is the status/control register.
- R3: A lookup can hit only while enable-register bit 10 (firmware cycles) and bit 8 (host-to-local forwarding) are both 1. With either bit clear, every lookup misses.
- R4: With translation enabled, a lookup hits exactly when ((host_addr[31:16] XOR host base) AND replace mask) is zero.
- R5: On a hit, xlat_addr[31:16] equals (local base AND replace mask) OR (host_addr[31:16] AND keep mask).
- R6: On a hit, xlat_addr[15:0] equals host_addr[15:0].
- R7: `xlat_valid` is 1 exactly one cycle after each cycle in which `host_valid` is 1, so back-to-back strobes give back-to-back results. `xlat_hit` is 0 whenever `xlat_valid` is 0.
- R8: A miss gives `xlat_hit`=0, and `xlat_addr` keeps the value of the last hit (zero if no hit has occurred since reset).
- R9: Writing the status register clears each status bit other than bit 17 whose write-data bit is 1, and leaves each bit whose write-data bit is 0 unchanged.
- R10: A 1 on `evt_set[n]` sets status bit n at the next edge for every n other than 17. When a set and a clear of the same bit fall in one cycle, the bit ends up 1. `evt_set[17]` is ignored.
- R11: Status bit 17 is the forwarding-mode bit, reported on `fwd_mode` and in `status_q[17]`. Every status write loads it from write-data bit 17. For example, writing only bit 17 as 1 sets the mode and leaves all other status bits unchanged.
- R12: A lookup strobed in the same cycle as a configuration write is judged against the register values held before that write.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge |
| rst_n | input | 1 | Asynchronous reset, active low |
| cfg_we | input | 1 | Register write strobe |
| cfg_sel | input | 2 | Register select (0 base, 1 mask, 2 enable, 3 status/control) |
| cfg_wdata | input | 32 | Register write data |
| evt_set | input | 32 | Per-bit status set pulses |
| host_valid | input | 1 | Host address strobe |
| host_addr | input | 32 | Host firmware-space address |
| xlat_valid | output | 1 | Result valid, one cycle after the strobe |
| xlat_hit | output | 1 | Window hit flag |
| xlat_addr | output | 32 | Translated local address |
| status_q | output | 32 | Status/control register contents |
| fwd_mode | output | 1 | Forwarding-mode bit |

## Verification
Two things can land on the same edge: a configuration write and a host lookup. The bench forces this by strobing a lookup in the very cycle that moves the host base, or that sets or clears an enable bit. The scoreboard expects the lookup to be judged with the old values, and expects the following lookup to be judged with the new ones. A status event pulse and a status clear of the same bit are also driven in one cycle, and the bench checks that the bit stays set.

// File: rtl/hrw_pkg.sv
package hrw_pkg;

   typedef enum logic [1:0] {
      SEL_BASE = 2'd0,
      SEL_MASK = 2'd1,
      SEL_ENAB = 2'd2,
      SEL_STAT = 2'd3
   } cfg_sel_e;

   localparam int unsigned DEF_ADDR_W   = 32;
   localparam int unsigned DEF_GRAN_W   = 16;
   localparam int unsigned DEF_FWH_BIT  = 10;
   localparam int unsigned DEF_FWD_BIT  = 8;
   localparam int unsigned DEF_MODE_BIT = 17;

endpackage

// File: rtl/hrw_cfg_regs.sv
module hrw_cfg_regs
   import hrw_pkg::*;
#(
   parameter int unsigned CFG_W    = 32,
   parameter int unsigned FWH_BIT  = DEF_FWH_BIT,
   parameter int unsigned FWD_BIT  = DEF_FWD_BIT,
   parameter int unsigned MODE_BIT = DEF_MODE_BIT
) (
   input  logic             clk,
   input  logic             rst_n,
   input  logic             cfg_we,
   input  logic [1:0]       cfg_sel,
   input  logic [CFG_W-1:0] cfg_wdata,
   input  logic [CFG_W-1:0] evt_set,
   output logic [CFG_W-1:0] base_q,
   output logic [CFG_W-1:0] mask_q,
   output logic             enab_ok,
   output logic [CFG_W-1:0] status_q
);

   logic [CFG_W-1:0] enab_q;
   logic             wr_base;
   logic             wr_mask;
   logic             wr_enab;
   logic             wr_stat;

   always_comb begin
      wr_base = cfg_we && (cfg_sel_e'(cfg_sel) == SEL_BASE);
      wr_mask = cfg_we && (cfg_sel_e'(cfg_sel) == SEL_MASK);
      wr_enab = cfg_we && (cfg_sel_e'(cfg_sel) == SEL_ENAB);
      wr_stat = cfg_we && (cfg_sel_e'(cfg_sel) == SEL_STAT);
   end

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         base_q <= '0;
         mask_q <= '0;
         enab_q <= '0;
      end else begin
         if (wr_base) base_q <= cfg_wdata;
         if (wr_mask) mask_q <= cfg_wdata;
         if (wr_enab) enab_q <= cfg_wdata;
      end
   end

   assign enab_ok = enab_q[FWH_BIT] & enab_q[FWD_BIT];

   for (genvar gi = 0; gi < CFG_W; gi++) begin : g_stat
      if (gi == MODE_BIT) begin : g_mode
         always_ff @(posedge clk or negedge rst_n) begin
            if (!rst_n)       status_q[gi] <= 1'b0;
            else if (wr_stat) status_q[gi] <= cfg_wdata[gi];
         end
      end else begin : g_w1c
         always_ff @(posedge clk or negedge rst_n) begin
            if (!rst_n) status_q[gi] <= 1'b0;
            else        status_q[gi] <= evt_set[gi] |
                                        (status_q[gi] & ~(wr_stat & cfg_wdata[gi]));
         end
      end
   end

endmodule

// File: rtl/hrw_window_match.sv
module hrw_window_match #(
   parameter int unsigned ADDR_W = 32,
   parameter int unsigned GRAN_W = 16,
   localparam int unsigned HI_W  = ADDR_W - GRAN_W,
   localparam int unsigned CFG_W = 2 * HI_W
) (
   input  logic [ADDR_W-1:0] host_addr,
   input  logic [CFG_W-1:0]  base_q,
   input  logic [CFG_W-1:0]  mask_q,
   input  logic              enab_ok,
   output logic              hit_raw,
   output logic [ADDR_W-1:0] xaddr
);

   logic [HI_W-1:0] host_hi;
   logic [HI_W-1:0] lbase;
   logic [HI_W-1:0] hbase;
   logic [HI_W-1:0] rep_m;
   logic [HI_W-1:0] keep_m;
   logic [HI_W-1:0] diff;
   logic [HI_W-1:0] hi_out;

   assign host_hi = host_addr[ADDR_W-1:GRAN_W];
   assign lbase   = base_q[CFG_W-1:HI_W];
   assign hbase   = base_q[HI_W-1:0];
   assign rep_m   = mask_q[CFG_W-1:HI_W];
   assign keep_m  = mask_q[HI_W-1:0];

   for (genvar gb = 0; gb < HI_W; gb++) begin : g_bit
      assign diff[gb]   = (host_hi[gb] ^ hbase[gb]) & rep_m[gb];
      assign hi_out[gb] = (rep_m[gb] & lbase[gb]) | (keep_m[gb] & host_hi[gb]);
   end

   assign hit_raw = enab_ok & ~(|diff);
   assign xaddr   = {hi_out, host_addr[GRAN_W-1:0]};

endmodule

// File: rtl/hrw_xlat_stage.sv
module hrw_xlat_stage #(
   parameter int unsigned ADDR_W = 32
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              host_valid,
   input  logic              hit_raw,
   input  logic [ADDR_W-1:0] xaddr,
   output logic              xlat_valid,
   output logic              xlat_hit,
   output logic [ADDR_W-1:0] xlat_addr
);

   logic take;
   assign take = host_valid & hit_raw;

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         xlat_valid <= 1'b0;
         xlat_hit   <= 1'b0;
         xlat_addr  <= '0;
      end else begin
         xlat_valid <= host_valid;
         xlat_hit   <= take;
         if (take) xlat_addr <= xaddr;
      end
   end

endmodule

// File: rtl/hrw_remap_window.sv
module hrw_remap_window
   import hrw_pkg::*;
#(
   parameter int unsigned ADDR_W   = DEF_ADDR_W,
   parameter int unsigned GRAN_W   = DEF_GRAN_W,
   parameter int unsigned FWH_BIT  = DEF_FWH_BIT,
   parameter int unsigned FWD_BIT  = DEF_FWD_BIT,
   parameter int unsigned MODE_BIT = DEF_MODE_BIT,
   localparam int unsigned HI_W    = ADDR_W - GRAN_W,
   localparam int unsigned CFG_W   = 2 * HI_W
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              cfg_we,
   input  logic [1:0]        cfg_sel,
   input  logic [CFG_W-1:0]  cfg_wdata,
   input  logic [CFG_W-1:0]  evt_set,
   input  logic              host_valid,
   input  logic [ADDR_W-1:0] host_addr,
   output logic              xlat_valid,
   output logic              xlat_hit,
   output logic [ADDR_W-1:0] xlat_addr,
   output logic [CFG_W-1:0]  status_q,
   output logic              fwd_mode
);

   if (GRAN_W == 0 || GRAN_W >= ADDR_W) begin : g_bad_gran
      $error("hrw_remap_window: GRAN_W must lie strictly between 0 and ADDR_W");
   end
   if (FWH_BIT >= CFG_W || FWD_BIT >= CFG_W || MODE_BIT >= CFG_W) begin : g_bad_bits
      $error("hrw_remap_window: control bit index outside register width");
   end
   if (FWH_BIT == FWD_BIT) begin : g_bad_en
      $error("hrw_remap_window: the two enable bits must differ");
   end

   logic [CFG_W-1:0]  base_q;
   logic [CFG_W-1:0]  mask_q;
   logic              enab_ok;
   logic              hit_raw;
   logic [ADDR_W-1:0] xaddr;

   hrw_cfg_regs #(
      .CFG_W    (CFG_W),
      .FWH_BIT  (FWH_BIT),
      .FWD_BIT  (FWD_BIT),
      .MODE_BIT (MODE_BIT)
   ) u_regs (
      .clk       (clk),
      .rst_n     (rst_n),
      .cfg_we    (cfg_we),
      .cfg_sel   (cfg_sel),
      .cfg_wdata (cfg_wdata),
      .evt_set   (evt_set),
      .base_q    (base_q),
      .mask_q    (mask_q),
      .enab_ok   (enab_ok),
      .status_q  (status_q)
   );

   hrw_window_match #(
      .ADDR_W (ADDR_W),
      .GRAN_W (GRAN_W)
   ) u_match (
      .host_addr (host_addr),
      .base_q    (base_q),
      .mask_q    (mask_q),
      .enab_ok   (enab_ok),
      .hit_raw   (hit_raw),
      .xaddr     (xaddr)
   );

   hrw_xlat_stage #(
      .ADDR_W (ADDR_W)
   ) u_stage (
      .clk        (clk),
      .rst_n      (rst_n),
      .host_valid (host_valid),
      .hit_raw    (hit_raw),
      .xaddr      (xaddr),
      .xlat_valid (xlat_valid),
      .xlat_hit   (xlat_hit),
      .xlat_addr  (xlat_addr)
   );

   assign fwd_mode = status_q[MODE_BIT];

endmodule

// File: rtl/hrw_remap_window_chk.sv
module hrw_remap_window_chk #(
   parameter int unsigned ADDR_W   = 32,
   parameter int unsigned GRAN_W   = 16,
   parameter int unsigned MODE_BIT = 17,
   localparam int unsigned CFG_W   = 2 * (ADDR_W - GRAN_W)
) (
   input logic              clk,
   input logic              rst_n,
   input logic              cfg_we,
   input logic [1:0]        cfg_sel,
   input logic [CFG_W-1:0]  cfg_wdata,
   input logic              host_valid,
   input logic [ADDR_W-1:0] host_addr,
   input logic              enab_ok,
   input logic              xlat_valid,
   input logic              xlat_hit,
   input logic [ADDR_W-1:0] xlat_addr,
   input logic              fwd_mode
);

   assert_valid_follows_R7: assert property (@(posedge clk) disable iff (!rst_n)
      host_valid |=> xlat_valid);

   assert_idle_quiet_R7: assert property (@(posedge clk) disable iff (!rst_n)
      !host_valid |=> (!xlat_valid && !xlat_hit));

   assert_disabled_misses_R3: assert property (@(posedge clk) disable iff (!rst_n)
      !enab_ok |=> !xlat_hit);

   assert_low_passthru_R6: assert property (@(posedge clk) disable iff (!rst_n)
      host_valid |=> (!xlat_hit || xlat_addr[GRAN_W-1:0] == $past(host_addr[GRAN_W-1:0])));

   assert_miss_holds_R8: assert property (@(posedge clk) disable iff (!rst_n)
      !xlat_hit |-> $stable(xlat_addr));

   assert_mode_load_R11: assert property (@(posedge clk) disable iff (!rst_n)
      (cfg_we && cfg_sel == 2'd3) |=> (fwd_mode == $past(cfg_wdata[MODE_BIT])));

endmodule

bind hrw_remap_window hrw_remap_window_chk #(
   .ADDR_W   (ADDR_W),
   .GRAN_W   (GRAN_W),
   .MODE_BIT (MODE_BIT)
) u_chk (
   .clk        (clk),
   .rst_n      (rst_n),
   .cfg_we     (cfg_we),
   .cfg_sel    (cfg_sel),
   .cfg_wdata  (cfg_wdata),
   .host_valid (host_valid),
   .host_addr  (host_addr),
   .enab_ok    (enab_ok),
   .xlat_valid (xlat_valid),
   .xlat_hit   (xlat_hit),
   .xlat_addr  (xlat_addr),
   .fwd_mode   (fwd_mode)
);

// File: tb/hrw_remap_window_tb.sv
`timescale 1ns/1ps
module hrw_remap_window_tb;

   logic        clk = 1'b0;
   logic        rst_n = 1'b0;
   logic        cfg_we = 1'b0;
   logic [1:0]  cfg_sel = '0;
   logic [31:0] cfg_wdata = '0;
   logic [31:0] evt_set = '0;
   logic        host_valid = 1'b0;
   logic [31:0] host_addr = '0;
   logic        xlat_valid;
   logic        xlat_hit;
   logic [31:0] xlat_addr;
   logic [31:0] status_q;
   logic        fwd_mode;

   int vectors = 0;
   int miscompares = 0;
   bit done = 1'b0;

   // bench-side register model
   logic [31:0] m_base = '0, m_mask = '0, m_enab = '0;
   logic [31:0] m_last = '0;
   logic [32:0] sb_q[$];
   string       sb_tag[$];

   always #4 clk = ~clk;

   hrw_remap_window u_dut (
      .clk(clk), .rst_n(rst_n), .cfg_we(cfg_we), .cfg_sel(cfg_sel),
      .cfg_wdata(cfg_wdata), .evt_set(evt_set), .host_valid(host_valid),
      .host_addr(host_addr), .xlat_valid(xlat_valid), .xlat_hit(xlat_hit),
      .xlat_addr(xlat_addr), .status_q(status_q), .fwd_mode(fwd_mode)
   );

   task automatic check(string req, logic [31:0] act, logic [31:0] exp);
      vectors++;
      if (act !== exp) begin
         miscompares++;
         $display("FAIL %s actual=%h expected=%h", req, act, exp);
      end
   endtask

   task automatic tick();
      @(negedge clk);
      cfg_we = 1'b0;
      host_valid = 1'b0;
      evt_set = '0;
   endtask

   task automatic put_cfg(logic [1:0] sel, logic [31:0] d);
      cfg_we = 1'b1; cfg_sel = sel; cfg_wdata = d;
      case (sel)
         2'd0: m_base = d;
         2'd1: m_mask = d;
         2'd2: m_enab = d;
         default: ;
      endcase
   endtask

   // R3 R4 R5 R6 R8 expected result from the model
   task automatic put_lookup(logic [31:0] a, string tag);
      logic h;
      h = m_enab[10] & m_enab[8] &
          (((a[31:16] ^ m_base[15:0]) & m_mask[31:16]) == 16'h0);
      if (h) m_last = {(m_base[31:16] & m_mask[31:16]) | (a[31:16] & m_mask[15:0]), a[15:0]};
      host_valid = 1'b1; host_addr = a;
      sb_q.push_back({h, m_last});
      sb_tag.push_back(tag);
   endtask

   // monitor: pops scoreboard items as results appear (R7)
   initial begin
      forever begin
         @(negedge clk);
         if (rst_n) begin
            if (xlat_valid) begin
               if (sb_q.size() == 0) begin
                  check("R7 unexpected result", 32'd1, 32'd0);
               end else begin
                  logic [32:0] e;
                  string t;
                  e = sb_q.pop_front();
                  t = sb_tag.pop_front();
                  check({t, " hit"}, {31'd0, xlat_hit}, {31'd0, e[32]});
                  check({t, " addr"}, xlat_addr, e[31:0]);
               end
            end else begin
               check("R7 hit idle", {31'd0, xlat_hit}, 32'd0);
            end
         end
      end
   end

   initial begin
      for (int c = 0; c < 100000; c++) begin
         @(posedge clk);
         if (done) break;
      end
      if (!done) begin
         miscompares++;
         vectors++;
         $display("FAIL watchdog expired");
         $display("== %0d vectors applied, %0d miscompares ==", vectors, miscompares);
         $finish;
      end
   end

   initial begin
      repeat (3) @(negedge clk);
      // R1 reset state
      check("R1 valid", {31'd0, xlat_valid}, 32'd0);
      check("R1 hit", {31'd0, xlat_hit}, 32'd0);
      check("R1 addr", xlat_addr, 32'd0);
      check("R1 status", status_q, 32'd0);
      check("R1 mode", {31'd0, fwd_mode}, 32'd0);
      rst_n = 1'b1;
      tick();
      put_lookup(32'h0000_0000, "R1 lookup after reset"); tick();

      // R2 R3: program a 1 MiB window, enable bits one at a time
      put_cfg(2'd0, 32'h9800_0E00); tick();
      put_cfg(2'd1, 32'hFFF0_000F); tick();
      put_cfg(2'd2, 32'h0000_0400); tick();
      put_lookup(32'h0E03_1234, "R3 fwh only"); tick();
      put_cfg(2'd2, 32'h0000_0100); tick();
      put_lookup(32'h0E03_1234, "R3 fwd only"); tick();
      put_cfg(2'd2, 32'h0000_0500); tick();
      // R4 R5 R6 hit, then back-to-back lookups (R7)
      put_lookup(32'h0E03_1234, "R5 hit"); tick();
      put_lookup(32'h0E0F_FFFF, "R6 top of window"); tick();
      put_lookup(32'h0F00_0000, "R8 miss holds"); tick();
      put_lookup(32'h0E00_0001, "R4 bottom of window"); tick();
      put_lookup(32'h0E10_0000, "R4 just above"); tick();
      tick();
      // 64 KiB window
      put_cfg(2'd1, 32'hFFFF_0000); tick();
      put_lookup(32'h0E00_ABCD, "R6 64K hit"); tick();
      put_lookup(32'h0E01_ABCD, "R4 64K miss"); tick();

      // R12 same-cycle write and lookup
      put_lookup(32'h2000_0010, "R12 old base");
      put_cfg(2'd0, 32'h4000_2000); tick();
      put_lookup(32'h2000_0010, "R12 new base"); tick();
      put_lookup(32'h2000_0020, "R12 old enable");
      put_cfg(2'd2, 32'h0000_0000); tick();
      put_lookup(32'h2000_0020, "R12 new enable"); tick();
      tick(); tick();
      check("R7 drained", sb_q.size(), 32'd0);

      // R9 R10 R11 status register
      evt_set = 32'h0002_00A5; tick(); tick();
      check("R10 set, bit17 ignored", status_q, 32'h0000_00A5);
      put_cfg(2'd3, 32'h0002_0000); tick();
      check("R11 mode set", status_q, 32'h0002_00A5);
      check("R11 mode out", {31'd0, fwd_mode}, 32'd1);
      put_cfg(2'd3, 32'h0000_0005); tick();
      check("R9 w1c", status_q, 32'h0000_00A0);
      check("R11 mode cleared", {31'd0, fwd_mode}, 32'd0);
      put_cfg(2'd3, 32'h0000_0020); evt_set = 32'h0000_0020; tick();
      check("R10 set wins", status_q, 32'h0000_00A0);
      put_cfg(2'd3, 32'h0000_0000); tick();
      check("R9 zero write keeps", status_q, 32'h0000_00A0);

      tick();
      done = 1'b1;
      $display("== %0d vectors applied, %0d miscompares ==", vectors, miscompares);
      $finish;
   end

endmodule